// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block controls an 18-pin parallel I/O port. Each pin is either a general-purpose I/O line owned by software or a line lent to a dedicated on-chip peripheral. A small register bus (address, write data, write strobe, read data) reaches four registers: a function-select register that picks GPIO or peripheral per pin, a direction register, an open-drain enable register and a data register.

On the pad side the block drives a value and an output enable for every pin and samples the pad inputs through a two-flop synchronizer. The synchronized levels feed both the data register read path and the input bus returned to the peripherals. Open-drain is emulated in logic: the pad is driven low for a 0 and released for a 1. The two highest pins have no open-drain capability.

The block is purely combinational from its registers to the pads. There is no state machine. The only sequential elements are the four registers and the synchronizer stages.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, the function-select, direction, open-drain and data-latch registers all read zero and every `pad_oe` bit is 0, so all pins are GPIO inputs.
- R2: A GPIO pin (function-select bit 0) with direction bit 1 and open-drain off drives `pad_out` with its data-latch bit and `pad_oe` = 1.
- R3: A write to the data register updates the latch whatever the pin's direction or function. For a GPIO input (direction bit 0) `pad_oe` is 0, and the held value appears on the pad once the direction bit is set.
- R4: A pin with function-select bit 1 takes `pad_out` from `periph_out` and `pad_oe` from `periph_oe`, and its direction bit has no effect.
- R5: A read of the data register (word address 3) returns the pad level sampled through two flops. A change on `pad_in` is visible after the second rising clock edge and not after the first. This holds for input, output and peripheral pins alike.
- R6: `periph_in` carries the same two-flop synchronized pad level as the data register read.
- R7: With open-drain enabled on a pin, `pad_out` is 0 and `pad_oe` is 1 only when that pin's output is enabled and its selected value is 0. This holds in both GPIO and peripheral mode.
- R8: Open-drain bits 16 and 17 cannot be set. They read as zero, and those pins stay push-pull.
- R9: The word addresses are 0 = function select, 1 = direction, 2 = open-drain, 3 = data. A write takes effect at the clock edge with `reg_we` high, and read-data bits 31..18 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 18 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data for the addressed register (combinational) |
| periph_out | input | 18 | Per-pin output values from the peripherals |
| periph_oe | input | 18 | Per-pin output enables from the peripherals |
| periph_in | output | 18 | Synchronized pad levels for the peripherals |
| pad_in | input | 18 | Raw pad input levels |
| pad_out | output | 18 | Pad output values |
| pad_oe | output | 18 | Pad output enables |

## Verification
The hardest situation to reach is one where every pin sits in a different combination of function, direction, open-drain, latch value and peripheral drive at the same time. Without that, a wrong mux priority can hide behind uniform settings. The bench sweeps 64 steps. At each step, pin i takes combination (7k+i) mod 64 of the six per-pin inputs, so all pins differ and every combination reaches every pin. The synchronizer latency is probed by changing `pad_in` on a falling edge and reading both before and after the second rising edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_PINS = 18;
    localparam int PORT_OD_PINS = 16;
    localparam int PORT_BUS_W = 32;

    typedef enum logic [1:0] {
        ADDR_FSEL = 2'd0,
        ADDR_DIR  = 2'd1,
        ADDR_ODEN = 2'd2,
        ADDR_DATA = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;
    logic [1:0]       fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    // counts edges since reset, used only to open the latency check window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fill_q <= 2'd0;
        else if (fill_q != 2'd2)
            fill_q <= fill_q + 2'd1;
    end

    assign dout = stage2_q;

    // R5
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int PINS    = 18,
    parameter int OD_PINS = 16,
    parameter int BUS_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             we,
    input  logic [PINS-1:0]  wdata,
    input  logic [PINS-1:0]  pin_lvl,
    output logic [PINS-1:0]  fsel_q,
    output logic [PINS-1:0]  dir_q,
    output logic [PINS-1:0]  oden_q,
    output logic [PINS-1:0]  latch_q,
    output logic [BUS_W-1:0] rdata
);
    localparam int PAD_BITS = BUS_W - PINS;

    function automatic logic [PINS-1:0] od_mask_f();
        logic [PINS-1:0] m;
        for (int i = 0; i < PINS; i++)
            m[i] = (i < OD_PINS);
        return m;
    endfunction

    localparam logic [PINS-1:0] OD_MASK = od_mask_f();

    reg_addr_e sel;
    logic [PINS-1:0] rd_word;

    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsel_q  <= '0;
            dir_q   <= '0;
            oden_q  <= '0;
            latch_q <= '0;
        end else if (we) begin
            unique case (sel)
                ADDR_FSEL: fsel_q  <= wdata;
                ADDR_DIR:  dir_q   <= wdata;
                ADDR_ODEN: oden_q  <= wdata & OD_MASK;
                ADDR_DATA: latch_q <= wdata;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            ADDR_FSEL: rd_word = fsel_q;
            ADDR_DIR:  rd_word = dir_q;
            ADDR_ODEN: rd_word = oden_q;
            ADDR_DATA: rd_word = pin_lvl;
        endcase
    end

    assign rdata = {{PAD_BITS{1'b0}}, rd_word};

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fsel_q == '0 && dir_q == '0 && oden_q == '0 && latch_q == '0));

    // R3
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd3) |=> (latch_q == $past(wdata)));

    // R9
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd1) |=> (dir_q == $past(wdata)));

    // R8
    od_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oden_q & ~OD_MASK) == '0);
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
    input  logic fsel,
    input  logic dir,
    input  logic oden,
    input  logic latch,
    input  logic p_out,
    input  logic p_oe,
    output logic pad_o,
    output logic pad_en
);
    logic val;
    logic en;

    always_comb begin
        val = fsel ? p_out : latch;
        en  = fsel ? p_oe  : dir;
        if (oden) begin
            pad_o  = 1'b0;
            pad_en = en & ~val;
        end else begin
            pad_o  = val;
            pad_en = en;
        end
    end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_port_pkg::*;
#(
    parameter int PINS    = PORT_PINS,
    parameter int OD_PINS = PORT_OD_PINS,
    parameter int BUS_W   = PORT_BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic [PINS-1:0]  reg_wdata,
    input  logic             reg_we,
    output logic [BUS_W-1:0] reg_rdata,
    input  logic [PINS-1:0]  periph_out,
    input  logic [PINS-1:0]  periph_oe,
    output logic [PINS-1:0]  periph_in,
    input  logic [PINS-1:0]  pad_in,
    output logic [PINS-1:0]  pad_out,
    output logic [PINS-1:0]  pad_oe
);
    logic [PINS-1:0] fsel_q;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] oden_q;
    logic [PINS-1:0] latch_q;
    logic [PINS-1:0] pin_lvl;

    gpio_sync #(.WIDTH(PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (pin_lvl)
    );

    gpio_regs #(.PINS(PINS), .OD_PINS(OD_PINS), .BUS_W(BUS_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .pin_lvl(pin_lvl),
        .fsel_q (fsel_q),
        .dir_q  (dir_q),
        .oden_q (oden_q),
        .latch_q(latch_q),
        .rdata  (reg_rdata)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        gpio_pin_cell u_cell (
            .fsel  (fsel_q[i]),
            .dir   (dir_q[i]),
            .oden  (oden_q[i]),
            .latch (latch_q[i]),
            .p_out (periph_out[i]),
            .p_oe  (periph_oe[i]),
            .pad_o (pad_out[i]),
            .pad_en(pad_oe[i])
        );
    end

    assign periph_in = pin_lvl;

    // R6
    periph_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd3) |-> (reg_rdata[PINS-1:0] == periph_in));
endmodule

// File: tb/gpio_mux_port_test.sv
`timescale 1ns/1ps
module gpio_mux_port_test;
    localparam int P = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [P-1:0]  reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic [31:0]   reg_rdata;
    logic [P-1:0]  periph_out = '0;
    logic [P-1:0]  periph_oe = '0;
    logic [P-1:0]  periph_in;
    logic [P-1:0]  pad_in = '0;
    logic [P-1:0]  pad_out;
    logic [P-1:0]  pad_oe;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    gpio_mux_port uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .periph_out(periph_out),
        .periph_oe(periph_oe), .periph_in(periph_in), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [P-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    initial begin
        #(4.0 * 200000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [P-1:0] fs, di, od, la, po, pe, val, en, odm, eo, ee;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 3; a++) begin
            rd(a[1:0], r);
            check(r == 0, "R1 reset register", r, 0);
        end
        rd(2'd3, r);
        check(r == 0, "R1 reset data read", r, 0);
        check(pad_oe == 0, "R1 reset pad_oe", {14'd0, pad_oe}, 0);

        // R9 map and upper bits
        wr(2'd0, 18'h3FFFF); rd(2'd0, r);
        check(r == 32'h0003FFFF, "R9 fsel readback", r, 32'h3FFFF);
        wr(2'd1, 18'h2A5A5); rd(2'd1, r);
        check(r == 32'h0002A5A5, "R9 dir readback", r, 32'h2A5A5);
        rd(2'd0, r);
        check(r == 32'h0003FFFF, "R9 fsel untouched", r, 32'h3FFFF);

        // R8 high open-drain bits stay clear
        wr(2'd2, 18'h3FFFF); rd(2'd2, r);
        check(r == 32'h0000FFFF, "R8 oden readback", r, 32'hFFFF);

        // R3 latch held while input, then driven
        wr(2'd0, 18'h0); wr(2'd2, 18'h0); wr(2'd1, 18'h0);
        wr(2'd3, 18'h15A3C);
        check(pad_oe == 0, "R3 input pins not driven", {14'd0, pad_oe}, 0);
        wr(2'd1, 18'h3FFFF);
        check(pad_out == 18'h15A3C, "R3 latch appears on output", {14'd0, pad_out}, 32'h15A3C);
        check(pad_oe == 18'h3FFFF, "R2 output enables", {14'd0, pad_oe}, 32'h3FFFF);

        // R8 pins 16/17 push-pull despite od write
        wr(2'd2, 18'h3FFFF); wr(2'd3, 18'h30000);
        check(pad_out[17:16] == 2'b11 && pad_oe[17:16] == 2'b11, "R8 high pins push-pull",
              {30'd0, pad_oe[17:16]}, 32'h3);

        // R2 R4 R7 sweep: pin i gets combination (7k+i) mod 64
        for (int k = 0; k < 64; k++) begin
            for (int i = 0; i < P; i++) begin
                int c = (7 * k + i) % 64;
                fs[i] = c[0]; di[i] = c[1]; od[i] = c[2];
                la[i] = c[3]; po[i] = c[4]; pe[i] = c[5];
            end
            wr(2'd0, fs); wr(2'd1, di); wr(2'd2, od); wr(2'd3, la);
            periph_out = po; periph_oe = pe;
            #0.5;
            odm = od & 18'h0FFFF;
            val = (fs & po) | (~fs & la);
            en  = (fs & pe) | (~fs & di);
            eo  = val & ~odm;
            ee  = (en & ~odm) | (en & odm & ~val);
            check(pad_out == eo, "R2 R4 R7 sweep pad_out", {14'd0, pad_out}, {14'd0, eo});
            check(pad_oe == ee, "R2 R4 R7 sweep pad_oe", {14'd0, pad_oe}, {14'd0, ee});
        end

        // R4 direction has no effect on peripheral pins
        wr(2'd0, 18'h3FFFF); wr(2'd2, 18'h0);
        periph_out = 18'h0F0F0; periph_oe = 18'h00FFF;
        wr(2'd1, 18'h0);
        check(pad_oe == 18'h00FFF && pad_out == 18'h0F0F0, "R4 dir clear", {14'd0, pad_oe}, 32'hFFF);
        wr(2'd1, 18'h3FFFF);
        check(pad_oe == 18'h00FFF && pad_out == 18'h0F0F0, "R4 dir set", {14'd0, pad_oe}, 32'hFFF);

        // R5 R6 synchronizer latency, with mixed pin modes
        wr(2'd0, 18'h000FF); wr(2'd1, 18'h0FF00);
        for (int t = 0; t < 4; t++) begin
            logic [P-1:0] oldv, newv;
            oldv = (t == 0) ? 18'h0 : 18'(32'h9E37 * t);
            newv = 18'(32'h9E37 * (t + 1) ^ 32'h2B5C3);
            @(negedge clk); pad_in = oldv;
            @(negedge clk); @(negedge clk);
            pad_in = newv;
            @(negedge clk);
            rd(2'd3, r);
            check(r[P-1:0] == oldv, "R5 not visible after one edge", r, {14'd0, oldv});
            @(negedge clk);
            rd(2'd3, r);
            check(r == {14'd0, newv}, "R5 visible after two edges", r, {14'd0, newv});
            check(periph_in == newv, "R6 periph_in synchronized", {14'd0, periph_in}, {14'd0, newv});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule